// File: doc/BRIEF.md
# System Bus Command and Fill Handshake Controller

This block sits between a processor's miss-handling logic and a shared system bus. An internal requester hands it one transaction at a time: a command kind, an address and, for reads, the index of a miss slot. The controller turns this into a 4-bit bus command code and drives the command and address pins together with an odd parity bit. It then holds them steady until the system answers with acknowledge or fail, and after that it goes back to the idle (NOP) code.

The controller tracks up to two outstanding read misses in two address slots. When the system warns that fill data is coming, the controller returns the address held in the slot that the warning selects, one cycle later, and frees that slot. The system can take the shared command/address pins or the 128-bit data bus away from the processor. The controller gives up either one on the clock edge after the request. While the system owns the command pins, the controller checks the parity of the commands the system drives.

Three status pulses report what went wrong: a failed locked write, a bus timeout, and a machine check. A machine check is raised by a timeout, by bad parity on an incoming command, and by a fill-error flag on returned data.

Top module: `sysbus_cmd_ctrl`

## Requirements
- R1: An accepted request drives `cmd_out` one cycle later with this code. Kinds 1 to 7 map to themselves: 0001 lock, 0010 fetch, 0011 fetch-modify, 0100 barrier, 0101 set-dirty, 0110 block write, 0111 locked block write. Kind 8 (read miss) drives 100 followed by `req_miss_id`. Kind 10 (read miss with intent to modify) drives 101 followed by `req_miss_id`. 0000 is the idle (NOP) code. `addr_out` carries the request address.
- R2: While `cmd_oe` is high, `cmd_out`, `addr_out` and `par_out` together hold an odd number of ones.
- R3: After issuing, the controller holds `cmd_out` and `addr_out` unchanged until `cmd_ack` or `cmd_fail` is sampled. On the next cycle it drives 0000. `req_ready` is low while a command is outstanding.
- R4: If `cmd_ack` and `cmd_fail` are sampled together while a locked block write (0111) is outstanding, `lock_fail` pulses for one cycle on the next cycle. The same pair of inputs on any other command gives no `lock_fail`.
- R5: If `cmd_fail` is sampled without `cmd_ack` while a command is outstanding, `tmo_err` and `mchk` pulse on the next cycle.
- R6: `dbus_req` sampled high at edge n makes `data_oe` low after edge n. `dbus_req` sampled low makes `data_oe` high after edge n, with `data_out` equal to `wr_data` as sampled at edge n.
- R7: `addr_req` sampled high makes `cmd_oe` low after that edge. `req_ready` stays low while `addr_req` is high and for the cycle after it falls, so no command is issued while the pins are released.
- R8: `fill_warn` sampled at edge n makes `fill_addr` equal to the address of slot `fill_id` (0 or 1) after edge n, with `fill_addr_vld` high for that one cycle. The slot is freed (`miss_busy[fill_id]` low).
- R9: Each read miss occupies slot `req_miss_id` (`miss_busy` bit set) from issue until its fill warning. A read request for a busy slot is not accepted (`req_ready` low).
- R10: `io_ref` is high while a command whose address has its top bit set is outstanding. That bit marks a noncached I/O reference.
- R11: While the pins are released (`cmd_oe` low), a nonzero `cmd_in` whose `cmd_in`, `addr_in` and `par_in` together hold an even number of ones raises `mchk` on the next cycle. With correct odd parity there is no `mchk`.
- R12: Each cycle with `fill_dvalid` and `fill_err` both high gives one cycle of `mchk` on the next cycle. `fill_err` without `fill_dvalid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request present |
| req_kind | input | 4 | Request kind (see R1) |
| req_addr | input | ADDR_W | Request address |
| req_miss_id | input | 1 | Miss slot for read kinds |
| req_ready | output | 1 | Request can be accepted this cycle |
| wr_data | input | DATA_W | Data to place on the data bus |
| cmd_out | output | 4 | Command code to the bus |
| addr_out | output | ADDR_W | Address to the bus |
| par_out | output | 1 | Odd parity over command and address |
| cmd_oe | output | 1 | Command/address/parity pins driven |
| cmd_in | input | 4 | Command driven by the system |
| addr_in | input | ADDR_W | Address driven by the system |
| par_in | input | 1 | Parity driven by the system |
| cmd_ack | input | 1 | Command acknowledge |
| cmd_fail | input | 1 | Command fail |
| addr_req | input | 1 | System wants the command/address pins |
| dbus_req | input | 1 | System wants the data bus |
| data_out | output | DATA_W | Data bus output |
| data_oe | output | 1 | Data bus driven |
| fill_warn | input | 1 | Fill is coming |
| fill_id | input | 1 | Miss slot of the coming fill |
| fill_dvalid | input | 1 | Returned data valid |
| fill_err | input | 1 | Returned data has an error |
| fill_addr | output | ADDR_W | Address of the slot being filled |
| fill_addr_vld | output | 1 | `fill_addr` valid |
| miss_busy | output | 2 | Occupied miss slots |
| io_ref | output | 1 | Outstanding command targets I/O space |
| lock_fail | output | 1 | Locked write failed (pulse) |
| tmo_err | output | 1 | Bus timeout (pulse) |
| mchk | output | 1 | Machine check (pulse) |

## Verification
The assertions assume the system never raises `addr_req` while a command is outstanding. They also assume that acknowledge and fail arrive only after a command has been issued, and that a fill warning names an occupied slot. The stimulus keeps to all three: each scenario closes its command with acknowledge or fail before it releases the pins, and it warns fills only for slots it has just loaded. The assertions also rely on request kinds coming from the legal set. Unlisted kinds are never accepted, and the bench drives none of them.

// File: rtl/sysbus_cmd_ctrl.sv
module sysbus_cmd_ctrl #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_miss_id,
  output logic              req_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [3:0]        cmd_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              par_out,
  output logic              cmd_oe,
  input  logic [3:0]        cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              par_in,
  input  logic              cmd_ack,
  input  logic              cmd_fail,
  input  logic              addr_req,
  input  logic              dbus_req,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              fill_warn,
  input  logic              fill_id,
  input  logic              fill_dvalid,
  input  logic              fill_err,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_addr_vld,
  output logic [1:0]        miss_busy,
  output logic              io_ref,
  output logic              lock_fail,
  output logic              tmo_err,
  output logic              mchk
);

  localparam logic [3:0] CODE_NOP  = 4'b0000;
  localparam logic [3:0] CODE_WLCK = 4'b0111;
  localparam int         IO_BIT    = ADDR_W - 1;

  logic              busy;
  logic              addr_req_q;
  logic              rd_kind;
  logic              kind_ok;
  logic              slot_free;
  logic              issue;
  logic              done;
  logic              in_perr;
  logic [3:0]        enc;
  logic [ADDR_W-1:0] slot_addr [2];

  // Request decode and encoding
  assign rd_kind   = req_kind[3];
  assign kind_ok   = (req_kind inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10});
  assign enc       = rd_kind ? {req_kind[3:1], req_miss_id} : req_kind;
  assign slot_free = !miss_busy[req_miss_id];
  assign req_ready = !busy && !addr_req && !addr_req_q && (!rd_kind || slot_free);
  assign issue     = req_valid && req_ready && kind_ok;
  assign done      = busy && (cmd_ack || cmd_fail);

  // Command/address pins
  assign cmd_oe  = !addr_req_q;
  assign par_out = ~^{cmd_out, addr_out};
  assign io_ref  = busy && addr_out[IO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cmd_out    <= CODE_NOP;
      addr_out   <= '0;
      addr_req_q <= 1'b0;
    end else begin
      addr_req_q <= addr_req;
      if (issue) begin
        busy     <= 1'b1;
        cmd_out  <= enc;
        addr_out <= req_addr;
      end else if (done) begin
        busy     <= 1'b0;
        cmd_out  <= CODE_NOP;
        addr_out <= '0;
      end
    end
  end

  // Miss slots
  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        miss_busy[s] <= 1'b0;
        slot_addr[s] <= '0;
      end else if (issue && rd_kind && (req_miss_id == 1'(s))) begin
        miss_busy[s] <= 1'b1;
        slot_addr[s] <= req_addr;
      end else if (fill_warn && (fill_id == 1'(s))) begin
        miss_busy[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_addr     <= '0;
      fill_addr_vld <= 1'b0;
    end else begin
      fill_addr_vld <= fill_warn;
      fill_addr     <= fill_warn ? slot_addr[fill_id] : '0;
    end
  end

  // Data bus
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= !dbus_req;
      data_out <= wr_data;
    end
  end

  // Status
  assign in_perr = addr_req_q && (cmd_in != CODE_NOP) && !(^{cmd_in, addr_in, par_in});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_fail <= 1'b0;
      tmo_err   <= 1'b0;
      mchk      <= 1'b0;
    end else begin
      lock_fail <= busy && cmd_ack && cmd_fail && (cmd_out == CODE_WLCK);
      tmo_err   <= busy && cmd_fail && !cmd_ack;
      mchk      <= (busy && cmd_fail && !cmd_ack) || in_perr || (fill_dvalid && fill_err);
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_ack && !cmd_fail |=> $stable(cmd_out) && $stable(addr_out));

  p_nop_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cmd_ack || cmd_fail) |=> (cmd_out == CODE_NOP) && !busy);

  p_tmo_mchk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> mchk);

  p_lock_not_tmo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fail |-> !tmo_err);

  p_dbus_yield_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_req |=> !data_oe);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_req |=> !cmd_oe && (cmd_out == CODE_NOP || busy));

  p_fill_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_warn |=> fill_addr_vld && !miss_busy[$past(fill_id)]);

endmodule

// File: tb/sysbus_cmd_ctrl_tb.sv
module sysbus_cmd_ctrl_tb;
  localparam int AW = 40;
  localparam int DW = 128;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [3:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic req_miss_id = 0;
  logic req_ready;
  logic [DW-1:0] wr_data = 0;
  logic [3:0] cmd_out;
  logic [AW-1:0] addr_out;
  logic par_out, cmd_oe;
  logic [3:0] cmd_in = 0;
  logic [AW-1:0] addr_in = 0;
  logic par_in = 0;
  logic cmd_ack = 0, cmd_fail = 0, addr_req = 0, dbus_req = 0;
  logic [DW-1:0] data_out;
  logic data_oe;
  logic fill_warn = 0, fill_id = 0, fill_dvalid = 0, fill_err = 0;
  logic [AW-1:0] fill_addr;
  logic fill_addr_vld;
  logic [1:0] miss_busy;
  logic io_ref, lock_fail, tmo_err, mchk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sysbus_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_miss_id(req_miss_id), .req_ready(req_ready),
    .wr_data(wr_data), .cmd_out(cmd_out), .addr_out(addr_out), .par_out(par_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in), .addr_in(addr_in), .par_in(par_in),
    .cmd_ack(cmd_ack), .cmd_fail(cmd_fail), .addr_req(addr_req), .dbus_req(dbus_req),
    .data_out(data_out), .data_oe(data_oe), .fill_warn(fill_warn), .fill_id(fill_id),
    .fill_dvalid(fill_dvalid), .fill_err(fill_err), .fill_addr(fill_addr),
    .fill_addr_vld(fill_addr_vld), .miss_busy(miss_busy), .io_ref(io_ref),
    .lock_fail(lock_fail), .tmo_err(tmo_err), .mchk(mchk));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] exp_code(input logic [3:0] k, input logic id);
    case (k)
      4'd8:    return {3'b100, id};
      4'd10:   return {3'b101, id};
      default: return k;
    endcase
  endfunction

  task automatic issue(input logic [3:0] k, input logic id, input logic [AW-1:0] a);
    req_valid = 1; req_kind = k; req_miss_id = id; req_addr = a;
    #1;
    chk(req_ready, "R3 ready when idle", req_ready, 1);
    tick();
    req_valid = 0;
    chk(cmd_out == exp_code(k, id), "R1 command code", cmd_out, exp_code(k, id));
    chk(addr_out == a, "R1 address", addr_out, a);
    chk(^{cmd_out, addr_out, par_out} == 1'b1, "R2 odd parity", par_out, ~^{cmd_out, addr_out});
  endtask

  task automatic reply(input logic a, input logic f);
    cmd_ack = a; cmd_fail = f;
    tick();
    cmd_ack = 0; cmd_fail = 0;
    chk(cmd_out == 4'd0, "R3 NOP after reply", cmd_out, 0);
  endtask

  task automatic t_reset();
    chk(cmd_out == 0, "R3 reset cmd", cmd_out, 0);
    chk(cmd_oe == 1, "R7 reset driving", cmd_oe, 1);
    chk(miss_busy == 0, "R9 reset slots", miss_busy, 0);
    chk(mchk == 0 && tmo_err == 0 && lock_fail == 0, "R5 reset status", {mchk, tmo_err, lock_fail}, 0);
    chk(req_ready == 1, "R3 reset ready", req_ready, 1);
  endtask

  task automatic t_encode();
    logic [3:0] kinds [7] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7};
    for (int i = 0; i < 7; i++) begin
      issue(kinds[i], 1'b0, 40'h00_1234_5670 + 40'(i * 16));
      reply(1, 0);
    end
    issue(4'd6, 1'b0, 40'h00_ABCD_EF00);
    tick(); tick();
    chk(cmd_out == 4'b0110, "R3 hold code", cmd_out, 4'b0110);
    chk(addr_out == 40'h00_ABCD_EF00, "R3 hold addr", addr_out, 40'h00_ABCD_EF00);
    chk(req_ready == 0, "R3 busy not ready", req_ready, 0);
    chk(^{cmd_out, addr_out, par_out} == 1'b1, "R2 parity while held", par_out, 0);
    reply(1, 0);
    chk(req_ready == 1, "R3 ready after reply", req_ready, 1);
  endtask

  task automatic t_lock();
    issue(4'd7, 1'b0, 40'h00_0000_1000);
    cmd_ack = 1; cmd_fail = 1;
    tick();
    cmd_ack = 0; cmd_fail = 0;
    chk(lock_fail == 1, "R4 locked write failed", lock_fail, 1);
    chk(tmo_err == 0 && mchk == 0, "R4 no timeout", {tmo_err, mchk}, 0);
    tick();
    chk(lock_fail == 0, "R4 single pulse", lock_fail, 0);
    issue(4'd6, 1'b0, 40'h00_0000_2000);
    cmd_ack = 1; cmd_fail = 1;
    tick();
    cmd_ack = 0; cmd_fail = 0;
    chk(lock_fail == 0, "R4 plain write no lock_fail", lock_fail, 0);
  endtask

  task automatic t_timeout();
    issue(4'd2, 1'b0, 40'h00_0000_3000);
    reply(0, 1);
    chk(tmo_err == 1, "R5 timeout", tmo_err, 1);
    chk(mchk == 1, "R5 machine check", mchk, 1);
    tick();
    chk(tmo_err == 0 && mchk == 0, "R5 pulse ends", {tmo_err, mchk}, 0);
  endtask

  task automatic t_dbus();
    dbus_req = 1; wr_data = 128'h1111;
    tick();
    chk(data_oe == 0, "R6 yield data bus", data_oe, 0);
    dbus_req = 0; wr_data = 128'hDEAD_BEEF_0123_4567;
    tick();
    chk(data_oe == 1, "R6 drive data bus", data_oe, 1);
    chk(data_out == 128'hDEAD_BEEF_0123_4567, "R6 data value", data_out[63:0], 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_release();
    addr_req = 1;
    req_valid = 1; req_kind = 4'd2; req_miss_id = 0; req_addr = 40'h00_0000_4000;
    #1;
    chk(req_ready == 0, "R7 not ready on request", req_ready, 0);
    tick();
    chk(cmd_oe == 0, "R7 pins released", cmd_oe, 0);
    chk(cmd_out == 0, "R7 no issue while released", cmd_out, 0);
    req_valid = 0;
    cmd_in = 4'b0010; addr_in = 40'h00_5555_0000;
    par_in = ^{cmd_in, addr_in};
    tick();
    chk(mchk == 1, "R11 bad incoming parity", mchk, 1);
    par_in = ~^{cmd_in, addr_in};
    tick();
    chk(mchk == 0, "R11 good incoming parity", mchk, 0);
    cmd_in = 0; addr_in = 0; par_in = 0;
    addr_req = 0;
    #1;
    chk(req_ready == 0, "R7 not ready cycle after drop", req_ready, 0);
    tick();
    chk(cmd_oe == 1, "R7 pins driven again", cmd_oe, 1);
    chk(req_ready == 1, "R7 ready again", req_ready, 1);
  endtask

  task automatic t_miss();
    issue(4'd8, 1'b0, 40'h00_AAAA_0000);
    reply(1, 0);
    issue(4'd10, 1'b1, 40'h00_BBBB_0000);
    reply(1, 0);
    chk(miss_busy == 2'b11, "R9 both slots busy", miss_busy, 2'b11);
    req_valid = 1; req_kind = 4'd8; req_miss_id = 0; req_addr = 40'h00_CCCC_0000;
    #1;
    chk(req_ready == 0, "R9 busy slot refused", req_ready, 0);
    req_valid = 0;
    fill_warn = 1; fill_id = 1;
    tick();
    fill_warn = 0;
    chk(cmd_out == 0, "R9 refused read not issued", cmd_out, 0);
    chk(fill_addr_vld == 1, "R8 fill valid", fill_addr_vld, 1);
    chk(fill_addr == 40'h00_BBBB_0000, "R8 slot 1 address", fill_addr, 40'h00_BBBB_0000);
    chk(miss_busy == 2'b01, "R8 slot 1 freed", miss_busy, 2'b01);
    fill_warn = 1; fill_id = 0;
    tick();
    fill_warn = 0;
    chk(fill_addr == 40'h00_AAAA_0000, "R8 slot 0 address", fill_addr, 40'h00_AAAA_0000);
    tick();
    chk(fill_addr_vld == 0, "R8 one-cycle valid", fill_addr_vld, 0);
    chk(miss_busy == 2'b00, "R9 slots free", miss_busy, 0);
  endtask

  task automatic t_io();
    issue(4'd2, 1'b0, 40'h80_0000_0100);
    chk(io_ref == 1, "R10 I/O reference", io_ref, 1);
    reply(1, 0);
    chk(io_ref == 0, "R10 cleared after reply", io_ref, 0);
    issue(4'd2, 1'b0, 40'h7F_0000_0100);
    chk(io_ref == 0, "R10 memory reference", io_ref, 0);
    reply(1, 0);
  endtask

  task automatic t_fill_err();
    fill_err = 1; fill_dvalid = 0;
    tick();
    chk(mchk == 0, "R12 no data no mchk", mchk, 0);
    fill_dvalid = 1;
    tick();
    chk(mchk == 1, "R12 first mchk", mchk, 1);
    tick();
    chk(mchk == 1, "R12 second mchk", mchk, 1);
    fill_err = 0;
    tick();
    chk(mchk == 0, "R12 clean data", mchk, 0);
    fill_dvalid = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_encode();
    t_lock();
    t_timeout();
    t_dbus();
    t_release();
    t_miss();
    t_io();
    t_fill_err();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule